// File: doc/BRIEF.md
# Chainable Four-Channel Countdown Timer Group

This block holds four down-counting timers that share a single prescaled count clock. Software programs each timer through a small register port: a reload value whose top bit halts the timer, and a live count register that can be read at any time or overwritten. A running timer counts down once per prescaled tick. Each time it runs out it sends a one-cycle pulse on its own interrupt line, reloads, and keeps going until software halts it.

A group control register selects the prescaler ratio. It can also join two neighbouring timers into one wider counter. In a joined pair the lower timer counts single ticks, and the upper timer counts the times the lower one wraps. Only the upper timer signals expiry. A per-pair rollover option makes the lower timer wrap through the full 32-bit range after each borrow, instead of reloading its programmed value. This lets a pair reach far beyond the 31-bit range of a single timer.

Top module: `tmr_grp_top`

## Requirements
- R1: After reset every live count reads 0, every reload register reads 0x80000000 (halted), the group control register reads 0 and all interrupt lines are low.
- R2: Control bits 9:8 pick the tick ratio: 0 gives 1 in 8 cycles, 1 gives 1 in 16, 2 gives 1 in 32 and 3 gives 1 in 64. Counting clock edges from 0 at the first edge after reset, edge e is a tick edge when (e mod ratio) = ratio-1.
- R3: While a timer is halted (reload bit 31 set; for the lower timer of a joined pair, the upper timer's bit 31), its live count does not change unless software writes it.
- R4: A write to a reload register of a halted timer also copies the value into the live count. A write while the timer runs changes only the reload register.
- R5: A running single timer loses 1 on each tick. On the tick that takes it from 1 to 0, its interrupt line is high for exactly the next cycle. On the following tick it reloads. So with reload value B, interrupts fall on ticks B, 2B+1, 3B+2 and so on after start.
- R6: A single timer counts with 31 bits: bit 31 of its reload register is never loaded into the count.
- R7: A write to a live count register sets it to the written value. On a tick edge the write takes precedence over the decrement.
- R8: Control bits 0, 1 and 2 join timers 0+1, 1+2 and 2+3. A join bit is ignored while the join just below it is in effect. A timer outside any effective join behaves as a single timer.
- R9: In a joined pair the lower timer uses all 32 bits and loses 1 per tick. On a tick where it is 0 it reloads and the upper timer loses 1. When the lower timer goes from 1 to 0 while the upper is 0, the upper timer's interrupt pulses. On the next tick both reload. The lower timer's interrupt stays low, and the pair runs or halts on the upper timer's bit 31.
- R10: When rollover bit 24+p of join p is set, the lower timer reloads to 0xFFFFFFFF on a borrow into a non-zero upper timer, instead of reloading its programmed value.
- R11: Register addresses are byte addresses. Timer n sits at n*0x40, with its live count at +0x00 and its reload at +0x10, and the control register is at 0x100. Other addresses read 0, and control bits other than 26:24, 9:8 and 2:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 9 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 4 | One-cycle expiry pulse per timer |

## Verification
A software write to a live count can land on the same edge as a prescaled tick, so the register path and the countdown path both try to update that count at once. The bench keeps its own model of the prescaler phase from edge numbers counted since reset. It places a count write exactly on a tick edge. It then reads back the written value, not a decremented one, and checks that the next tick decrements from there. Expiry pulses are predicted as edge numbers and matched in order against the edges where each interrupt line rises.

// File: rtl/tmr_grp_pkg.sv
// Shared constants for the timer group: default sizes and the
// register slot codes inside one timer's address window.
package tmr_grp_pkg;
    localparam int unsigned TMR_NUM_DEF  = 4;
    localparam int unsigned TMR_CNT_W    = 32;
    localparam int unsigned TMR_ADDR_W   = 9;
    localparam int unsigned TMR_PSC_SEL_W = 2;
    localparam int unsigned TMR_PSC_BASE_LG = 3;

    typedef enum logic [1:0] {
        SLOT_LIVE   = 2'd0,
        SLOT_RELOAD = 2'd1
    } tmr_slot_e;
endpackage

// File: rtl/tmr_grp_prescale.sv
// Shared tick generator. A free-running counter is masked by the
// selected ratio (2**(BASE_LG+sel)); tick is high for one cycle when
// the masked bits are all ones. Assumes the ratio is at least 2 so
// ticks are never adjacent.
module tmr_grp_prescale #(
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned BASE_LG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int unsigned CW = BASE_LG + (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Free-running phase counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Low-bit mask for the selected ratio and the tick decision.
    always_comb begin
        lim  = ~({CW{1'b1}} << (BASE_LG + int'(div_sel)));
        tick = ((cnt_q & lim) == lim);
    end
endmodule

// File: rtl/tmr_grp_link.sv
// Resolves the join bits into effective pairs (a join is dropped when
// the join below it is active) and derives each timer's role and run
// state from the halt bits. Pure combinational logic.
module tmr_grp_link #(
    parameter int unsigned NUM_TMR = 4
) (
    input  logic [NUM_TMR-2:0] join_req,
    input  logic [NUM_TMR-1:0] halt,
    output logic [NUM_TMR-1:0] is_lo,
    output logic [NUM_TMR-1:0] is_hi,
    output logic [NUM_TMR-1:0] run
);
    localparam int unsigned NPAIR = NUM_TMR - 1;

    logic [NPAIR-1:0] eff;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        if (p == 0) begin : g_first
            assign eff[p] = join_req[p];
        end else begin : g_rest
            assign eff[p] = join_req[p] & ~eff[p-1];
        end
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_role
        if (i < NPAIR) begin : g_can_lo
            assign is_lo[i] = eff[i];
            assign run[i]   = eff[i] ? ~halt[i+1] : ~halt[i];
        end else begin : g_no_lo
            assign is_lo[i] = 1'b0;
            assign run[i]   = ~halt[i];
        end
        if (i > 0) begin : g_can_hi
            assign is_hi[i] = eff[i-1];
        end else begin : g_no_hi
            assign is_hi[i] = 1'b0;
        end
    end
endmodule

// File: rtl/tmr_grp_chan.sv
// One countdown channel. Holds the live count, the reload register
// (bit CNT_W-1 = halt) and the registered expiry pulse. Role inputs say
// whether it is single, the lower or the upper half of a pair; mate_*
// describe the partner's live count. Assumes role, run and mate inputs
// are stable combinational functions of register state.
module tmr_grp_chan #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             is_lo,
    input  logic             is_hi,
    input  logic             rovr,
    input  logic             mate_zero,
    input  logic             mate_one,
    input  logic             wr_live,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] reload,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] HALT_VAL = {1'b1, {(CNT_W-1){1'b0}}};

    logic             at_zero;
    logic             at_one;
    logic [CNT_W-1:0] reload_cnt;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] next_cnt;
    logic             fire;

    // Count value taken from the reload register, by role.
    always_comb begin
        at_zero    = (live == '0);
        at_one     = (live == CNT_W'(1));
        reload_cnt = is_lo ? reload : {1'b0, reload[CNT_W-2:0]};
        load_val   = is_lo ? wdata  : {1'b0, wdata[CNT_W-2:0]};
    end

    // Next count on a tick and whether this tick expires the channel.
    always_comb begin
        next_cnt = live;
        fire     = 1'b0;
        if (is_hi) begin
            if (mate_zero) next_cnt = at_zero ? reload_cnt : live - 1'b1;
            fire = mate_one & at_zero;
        end else if (is_lo) begin
            if (at_zero) next_cnt = (mate_zero | ~rovr) ? reload_cnt : ALL_ONES;
            else         next_cnt = live - 1'b1;
        end else begin
            next_cnt = at_zero ? reload_cnt : live - 1'b1;
            fire     = at_one;
        end
    end

    // Register update: software writes first, then the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= '0;
            reload <= HALT_VAL;
            irq    <= 1'b0;
        end else begin
            irq <= tick & run & fire & ~wr_live;
            if (wr_reload) reload <= wdata;
            if (wr_live)                  live <= wdata;
            else if (wr_reload && !run)   live <= load_val;
            else if (tick && run)         live <= next_cnt;
        end
    end
endmodule

// File: rtl/tmr_grp_top.sv
// Timer group top: register decode and read mux, the group control
// register, the prescaler, the join resolver and one channel per timer.
// Reads are combinational; writes take effect on the clock edge.
module tmr_grp_top
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NUM_TMR = TMR_NUM_DEF,
    parameter int unsigned CNT_W   = TMR_CNT_W,
    parameter int unsigned ADDR_W  = TMR_ADDR_W,
    parameter int unsigned PSC_W   = TMR_PSC_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [NUM_TMR-1:0] irq
);
    localparam int unsigned NPAIR    = NUM_TMR - 1;
    localparam int unsigned SLOT_LSB = 4;
    localparam int unsigned IDX_LSB  = 6;
    localparam int unsigned IDX_W    = $clog2(NUM_TMR);
    localparam int unsigned WIN_MSB  = IDX_LSB + IDX_W;
    localparam int unsigned DIV_LSB  = 8;
    localparam int unsigned ROVR_LSB = 24;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1 << WIN_MSB);
    localparam logic [CNT_W-1:0] CTRL_MASK =
        CNT_W'(((1 << PSC_W) - 1) << DIV_LSB) |
        CNT_W'((1 << NPAIR) - 1) |
        CNT_W'(((1 << NPAIR) - 1) << ROVR_LSB);

    logic [CNT_W-1:0]              ctrl_q;
    logic                          tick;
    logic                          ctrl_hit;
    logic                          tmr_hit;
    logic [IDX_W-1:0]              idx;
    tmr_slot_e                     slot;
    logic [NUM_TMR-1:0]            wr_cur_v;
    logic [NUM_TMR-1:0]            wr_base_v;
    logic [NUM_TMR-1:0]            halt_v;
    logic [NUM_TMR-1:0]            is_lo_v;
    logic [NUM_TMR-1:0]            is_hi_v;
    logic [NUM_TMR-1:0]            run_v;
    logic [NUM_TMR-1:0]            cur_zero;
    logic [NUM_TMR-1:0]            cur_one;
    logic [NUM_TMR-1:0][CNT_W-1:0] cur_all;
    logic [NUM_TMR-1:0][CNT_W-1:0] base_all;

    // Address decode for the control register and the timer windows.
    always_comb begin
        ctrl_hit = (reg_addr == CTRL_ADDR);
        tmr_hit  = (reg_addr[ADDR_W-1:WIN_MSB] == '0) &&
                   (reg_addr[SLOT_LSB-1:0] == '0);
        idx      = reg_addr[WIN_MSB-1:IDX_LSB];
        slot     = tmr_slot_e'(reg_addr[IDX_LSB-1:SLOT_LSB]);
    end

    // Group control register; unimplemented bits are dropped on write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (reg_we && ctrl_hit) ctrl_q <= reg_wdata & CTRL_MASK;
    end

    // Read mux over control, live counts and reload registers.
    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit) begin
            reg_rdata = ctrl_q;
        end else if (tmr_hit) begin
            case (slot)
                SLOT_LIVE:   reg_rdata = cur_all[idx];
                SLOT_RELOAD: reg_rdata = base_all[idx];
                default:     reg_rdata = '0;
            endcase
        end
    end

    tmr_grp_prescale #(
        .SEL_W   (PSC_W),
        .BASE_LG (TMR_PSC_BASE_LG)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (ctrl_q[DIV_LSB +: PSC_W]),
        .tick    (tick)
    );

    tmr_grp_link #(
        .NUM_TMR (NUM_TMR)
    ) u_link (
        .join_req (ctrl_q[NPAIR-1:0]),
        .halt     (halt_v),
        .is_lo    (is_lo_v),
        .is_hi    (is_hi_v),
        .run      (run_v)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
        logic lo_mz, hi_mz, hi_mo, rovr_i;

        assign wr_cur_v[i]  = reg_we & tmr_hit & (idx == IDX_W'(i)) & (slot == SLOT_LIVE);
        assign wr_base_v[i] = reg_we & tmr_hit & (idx == IDX_W'(i)) & (slot == SLOT_RELOAD);
        assign halt_v[i]    = base_all[i][CNT_W-1];
        assign cur_zero[i]  = (cur_all[i] == '0);
        assign cur_one[i]   = (cur_all[i] == CNT_W'(1));

        if (i < NPAIR) begin : g_up
            assign lo_mz  = cur_zero[i+1];
            assign rovr_i = ctrl_q[ROVR_LSB + i];
        end else begin : g_no_up
            assign lo_mz  = 1'b0;
            assign rovr_i = 1'b0;
        end
        if (i > 0) begin : g_dn
            assign hi_mz = cur_zero[i-1];
            assign hi_mo = cur_one[i-1];
        end else begin : g_no_dn
            assign hi_mz = 1'b0;
            assign hi_mo = 1'b0;
        end

        tmr_grp_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .run       (run_v[i]),
            .is_lo     (is_lo_v[i]),
            .is_hi     (is_hi_v[i]),
            .rovr      (rovr_i),
            .mate_zero (is_lo_v[i] ? lo_mz : hi_mz),
            .mate_one  (hi_mo),
            .wr_live   (wr_cur_v[i]),
            .wr_reload (wr_base_v[i]),
            .wdata     (reg_wdata),
            .live      (cur_all[i]),
            .reload    (base_all[i]),
            .irq       (irq[i])
        );
    end
endmodule

// File: rtl/tmr_grp_chk.sv
// Property checker for the timer group, bound into tmr_grp_top.
// Observes the tick, roles, run state, write strobes, counts and
// interrupt lines; holds no design state of its own.
module tmr_grp_chk #(
    parameter int unsigned NUM_TMR = 4,
    parameter int unsigned CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick,
    input logic [NUM_TMR-1:0]            irq,
    input logic [NUM_TMR-1:0]            run,
    input logic [NUM_TMR-1:0]            is_lo,
    input logic [NUM_TMR-1:0]            wr_cur,
    input logic [NUM_TMR-1:0]            wr_base,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cur
);
    // R2: the prescaled tick never lasts two cycles.
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("p_tick_spacing_r2");

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        // R5: an expiry pulse lasts exactly one cycle.
        p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i])
            else $error("p_irq_pulse_r5");

        // R5: a pulse only follows a tick edge.
        p_irq_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(tick))
            else $error("p_irq_after_tick_r5");

        // R9: the lower half of a pair never raises its own line.
        p_lower_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(is_lo[i]) |-> !irq[i])
            else $error("p_lower_silent_r9");

        // R3: a halted timer's count holds unless software writes it.
        p_hold_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !wr_cur[i] && !wr_base[i]) |=> $stable(cur[i]))
            else $error("p_hold_halted_r3");
    end
endmodule

bind tmr_grp_top tmr_grp_chk #(
    .NUM_TMR (NUM_TMR),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .irq     (irq),
    .run     (run_v),
    .is_lo   (is_lo_v),
    .wr_cur  (wr_cur_v),
    .wr_base (wr_base_v),
    .cur     (cur_all)
);

// File: tb/tmr_grp_top_tb.sv
// Scoreboard bench: scenario code predicts interrupt edges into a queue,
// a monitor pops and matches them as the lines pulse; register readbacks
// are checked directly.
module tmr_grp_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    longint edge_n = -1;
    int     q_ch[$];
    longint q_edge[$];

    tmr_grp_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

    function automatic logic [8:0] a_live(input int n);
        return 9'(n * 64);
    endfunction
    function automatic logic [8:0] a_rel(input int n);
        return 9'(n * 64 + 16);
    endfunction
    localparam logic [8:0] A_CTRL = 9'h100;

    // Edge of the n-th tick (1-based) strictly after edge s.
    function automatic longint tk(input longint s, input int n, input int dv);
        longint t0;
        t0 = s - (s % dv) + dv - 1;
        if (t0 == s) t0 = t0 + dv;
        return t0 + longint'(n - 1) * dv;
    endfunction
    // Number of tick edges in (s, r].
    function automatic longint nticks(input longint s, input longint r, input int dv);
        return (r + 1) / dv - (s + 1) / dv;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d, output longint s);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        s = edge_n;
        reg_we = 1'b0;
    endtask

    task automatic wr0(input logic [8:0] a, input logic [31:0] d);
        longint s;
        wr(a, d, s);
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic wait_to(input longint e);
        while (edge_n < e) @(negedge clk);
    endtask

    task automatic expect_irq(input int ch, input longint e);
        q_ch.push_back(ch);
        q_edge.push_back(e);
    endtask

    task automatic drain(input string tag);
        n_chk++;
        if (q_ch.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing irq act=%0d pending exp=0", tag, q_ch.size());
            q_ch.delete();
            q_edge.delete();
        end
    endtask

    // Monitor: every pulse must match the next predicted (channel, edge).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < 4; ch++) begin
                if (irq[ch]) begin
                    n_chk++;
                    if (q_ch.size() == 0) begin
                        n_fail++;
                        $display("FAIL irq R5 R8 R9 unexpected act=ch%0d@%0d exp=none", ch, edge_n);
                    end else begin
                        int     ec;
                        longint ee;
                        ec = q_ch.pop_front();
                        ee = q_edge.pop_front();
                        if (ec != ch || ee != edge_n) begin
                            n_fail++;
                            $display("FAIL irq R2 R5 R9 act=ch%0d@%0d exp=ch%0d@%0d",
                                     ch, edge_n, ec, ee);
                        end
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint s, s1, r, sw;
        logic [31:0] d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(a_live(0), d);  chk("R1 live0", d, 32'h0);
        rd(a_rel(3), d);   chk("R1 reload3", d, 32'h8000_0000);
        rd(A_CTRL, d);     chk("R1 ctrl", d, 32'h0);
        chk("R1 irq", {28'h0, irq}, 32'h0);

        // R11: unmapped addresses and control bit mask
        rd(9'h020, d);     chk("R11 unmapped slot", d, 32'h0);
        rd(9'h104, d);     chk("R11 unmapped high", d, 32'h0);
        wr0(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d);     chk("R11 ctrl mask", d, 32'h0700_0307);
        wr0(A_CTRL, 32'h0);

        // R6 / R4: halted reload write loads 31-bit count
        wr0(a_rel(0), 32'h8000_0005);
        rd(a_live(0), d);  chk("R6 R4 load on halted write", d, 32'd5);
        // R3: halted count holds
        repeat (40) @(negedge clk);
        rd(a_live(0), d);  chk("R3 halted hold", d, 32'd5);

        // R5: single timer periodic expiry, ratio 8
        wr(a_rel(0), 32'd5, s);
        expect_irq(0, tk(s, 5, 8));
        expect_irq(0, tk(s, 11, 8));
        expect_irq(0, tk(s, 17, 8));
        wait_to(tk(s, 2, 8));
        rd(a_live(0), d);  chk("R5 mid count", d, 32'd3);
        wait_to(tk(s, 17, 8) + 2);
        wr0(a_rel(0), 32'h8000_0005);
        repeat (60) @(negedge clk);
        drain("R5");
        rd(a_live(0), d);  chk("R3 hold after halt", d, 32'd0);

        // R4: reload write while running leaves the count alone
        wr0(a_rel(1), 32'h8000_0014);
        wr(a_rel(1), 32'h0000_0014, s1);
        wr0(a_rel(1), 32'h0000_0007);
        r = edge_n;
        rd(a_live(1), d);  chk("R4 running write", d, 32'(20 - nticks(s1, r, 8)));
        rd(a_rel(1), d);   chk("R4 reload updated", d, 32'd7);
        wr0(a_rel(1), 32'h8000_0007);
        wr0(a_live(1), 32'h0);
        rd(a_live(1), d);  chk("R7 plain write", d, 32'h0);

        // R2: ratio 16 then 64
        wr0(A_CTRL, 32'h0000_0100);
        rd(A_CTRL, d);     chk("R2 ctrl readback", d, 32'h0000_0100);
        wr0(a_rel(2), 32'h8000_0003);
        wr(a_rel(2), 32'd3, s);
        expect_irq(2, tk(s, 3, 16));
        expect_irq(2, tk(s, 7, 16));
        wait_to(tk(s, 7, 16) + 2);
        wr0(a_rel(2), 32'h8000_0003);
        repeat (40) @(negedge clk);
        drain("R2 ratio16");
        wr0(A_CTRL, 32'h0000_0300);
        wr0(a_rel(2), 32'h8000_0002);
        wr(a_rel(2), 32'd2, s);
        expect_irq(2, tk(s, 2, 64));
        expect_irq(2, tk(s, 5, 64));
        wait_to(tk(s, 5, 64) + 2);
        wr0(a_rel(2), 32'h8000_0002);
        repeat (80) @(negedge clk);
        drain("R2 ratio64");

        // R7: count write lands on a tick edge and wins
        wr0(A_CTRL, 32'h0);
        wr0(a_rel(3), 32'h8000_0100);
        wr0(a_rel(3), 32'h0000_0100);
        while (edge_n % 8 != 6) @(negedge clk);
        wr(a_live(3), 32'h40, sw);
        chk("R7 write on tick edge phase", 32'(sw % 8), 32'd7);
        rd(a_live(3), d);  chk("R7 write beats tick", d, 32'h40);
        wait_to(sw + 8);
        rd(a_live(3), d);  chk("R7 next tick decrements", d, 32'h3F);
        wr0(a_rel(3), 32'h8000_0100);
        wr0(a_live(3), 32'h0);

        // R9: joined pair 0+1
        wr0(A_CTRL, 32'h0000_0001);
        wr0(a_rel(0), 32'd3);
        wr0(a_rel(1), 32'h8000_0001);
        wr(a_rel(1), 32'd1, s);
        expect_irq(1, tk(s, 7, 8));
        expect_irq(1, tk(s, 15, 8));
        wait_to(tk(s, 4, 8));
        rd(a_live(1), d);  chk("R9 upper borrowed", d, 32'd0);
        rd(a_live(0), d);  chk("R9 lower reloaded", d, 32'd3);
        wait_to(tk(s, 15, 8) + 2);
        wr0(a_rel(1), 32'h8000_0001);
        repeat (40) @(negedge clk);
        drain("R9");

        // R10: rollover reload to all ones
        wr0(A_CTRL, 32'h0100_0001);
        wr0(a_rel(0), 32'd3);
        wr0(a_rel(1), 32'h8000_0001);
        wr0(a_live(0), 32'd1);
        wr(a_rel(1), 32'd1, s);
        wait_to(tk(s, 2, 8));
        rd(a_live(0), d);  chk("R10 lower full wrap", d, 32'hFFFF_FFFF);
        rd(a_live(1), d);  chk("R10 upper borrowed", d, 32'd0);
        wr0(a_rel(1), 32'h8000_0001);
        repeat (20) @(negedge clk);
        drain("R10");

        // R8: join 1+2 ignored while join 0+1 is active
        wr0(A_CTRL, 32'h0000_0003);
        wr0(a_live(1), 32'd5);
        wr0(a_live(2), 32'd0);
        wr0(a_rel(2), 32'h8000_0002);
        wr(a_rel(2), 32'd2, s);
        expect_irq(2, tk(s, 2, 8));
        expect_irq(2, tk(s, 5, 8));
        wait_to(tk(s, 5, 8) + 2);
        wr0(a_rel(2), 32'h8000_0002);
        repeat (40) @(negedge clk);
        drain("R8");
        rd(a_live(1), d);  chk("R8 R3 halted upper of pair0", d, 32'd5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule